// File: doc/BRIEF.md
# Sticky-Jamming Wide Right Shifter

This block shifts a wide unsigned value to the right by an unsigned count, as is done when two floating-point significands are aligned before they are added. A plain shifter throws away every bit that falls off the low end. This one keeps a summary of them: the OR of all discarded bits is folded into bit 0 of the result. A rounding stage further down the datapath can then still tell an exact alignment from an inexact one.

The value arrives and leaves as two equal halves, high and low. The default width is two 64-bit halves. The count is unsigned, 8 bits by default. Any count at or above the full width flushes the whole operand into the sticky position. The block has no clock or state: the result follows the inputs combinationally.

Internally the count is first sorted into one of three ranges. The ranges are named ZERO (count of zero), INSIDE (count from 1 to width minus 1) and FLUSH (count at or above the width). The path is selected by a unique case on that range, not by a state register. In the INSIDE range, a chain of power-of-two shift stages is built by a generate loop. Each enabled stage shifts by its own amount and adds the bits it drops to a running sticky flag. The half width must be a power of two.

Top module: `jam_shift_right`

## Requirements
- R1: With a count of 0, the output halves equal the input halves exactly, and no sticky bit is added.
- R2: With a count c from 1 to 63, the result is the 128-bit input shifted right by c, so the low c bits of the high half enter the top of the low half. Bit 0 of the result is ORed with the OR of the c bits dropped from the low half.
- R3: With a count of exactly 64, the high output half is zero. The low output half is the old high half, with bit 0 ORed with 1 when any bit of the old low half was set.
- R4: With a count c from 65 to 127, the high output half is zero and the low output half is the old high half shifted right by c minus 64. Its bit 0 is ORed with the OR of every discarded bit from both halves.
- R5: With a count from 128 to 255, the high output half is zero and the low output half is 1 when any input bit was set, else 0.
- R6: For every count, the output is nonzero exactly when the input is nonzero, and the output, read as a 128-bit unsigned number, never exceeds the input.
- R7: The output is purely combinational: a new input value appears at the output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_hi_i | input | 64 | Upper half of the operand |
| in_lo_i | input | 64 | Lower half of the operand |
| count_i | input | 8 | Unsigned right-shift amount |
| out_hi_o | output | 64 | Upper half of the shifted result |
| out_lo_o | output | 64 | Lower half of the shifted result; bit 0 carries the sticky OR |

## Verification
The bench builds the block with its default parameters: 64-bit halves and an 8-bit count. That count width reaches every count from 0 through 255. So the pass-through at 0, the partial shifts, the exact half-width boundary at 64, the cross-half range and the whole FLUSH range up to 255 are all applied, each with all-ones, single-bit and random operands. The single-bit operands put the one set bit exactly at or just past the discard boundary, which tests whether the sticky flag is set or left clear.

// File: rtl/jam_shift_pkg.sv
package jam_shift_pkg;

    localparam int unsigned HALF_W_DEFAULT = 64;
    localparam int unsigned CNT_W_DEFAULT  = 8;

    // Range the count falls into; selects the output path.
    typedef enum logic [1:0] {
        RANGE_ZERO   = 2'd0,
        RANGE_INSIDE = 2'd1,
        RANGE_FLUSH  = 2'd2
    } shift_range_e;

endpackage

// File: rtl/jam_count_class.sv
module jam_count_class
    import jam_shift_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [CNT_W-1:0] count_i,
    output shift_range_e     range_o
);
    localparam int unsigned STAGES = $clog2(DATA_W);

    logic flush;

    generate
        if (CNT_W > STAGES) begin : g_wide_count
            assign flush = |count_i[CNT_W-1:STAGES];
        end else begin : g_narrow_count
            assign flush = 1'b0;
        end
    endgenerate

    always_comb begin
        if (flush) begin
            range_o = RANGE_FLUSH;
        end else if (count_i == '0) begin
            range_o = RANGE_ZERO;
        end else begin
            range_o = RANGE_INSIDE;
        end
    end

    always_comb begin
        assert_flush_range_R5: assert ((int'(count_i) >= int'(DATA_W)) == (range_o == RANGE_FLUSH))
            else $error("count class disagrees with numeric flush bound");
    end

endmodule

// File: rtl/jam_shift_stage.sv
module jam_shift_stage #(
    parameter int unsigned W   = 128,
    parameter int unsigned AMT = 1
) (
    input  logic [W-1:0] d_i,
    input  logic         sticky_i,
    input  logic         en_i,
    output logic [W-1:0] q_o,
    output logic         sticky_o
);
    logic dropped;

    assign dropped = |d_i[AMT-1:0];

    always_comb begin
        if (en_i) begin
            q_o      = d_i >> AMT;
            sticky_o = sticky_i | dropped;
        end else begin
            q_o      = d_i;
            sticky_o = sticky_i;
        end
    end

    always_comb begin
        assert_stage_keeps_info_R6: assert ((|d_i | sticky_i) == (|q_o | sticky_o))
            else $error("stage lost a set bit");
    end

endmodule

// File: rtl/jam_shift_right.sv
module jam_shift_right
    import jam_shift_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEFAULT,
    parameter int unsigned CNT_W  = CNT_W_DEFAULT
) (
    input  logic [HALF_W-1:0] in_hi_i,
    input  logic [HALF_W-1:0] in_lo_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [HALF_W-1:0] out_hi_o,
    output logic [HALF_W-1:0] out_lo_o
);
    localparam int unsigned DATA_W = 2 * HALF_W;
    localparam int unsigned STAGES = $clog2(DATA_W);
    localparam int unsigned EXT_W  = STAGES + CNT_W;

    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] result;
    logic [EXT_W-1:0]  count_ext;
    shift_range_e      range_sel;

    logic [DATA_W-1:0] chain  [0:STAGES];
    logic              sticky [0:STAGES];

    assign operand   = {in_hi_i, in_lo_i};
    assign count_ext = {{STAGES{1'b0}}, count_i};

    jam_count_class #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) count_class_i (
        .count_i (count_i),
        .range_o (range_sel)
    );

    assign chain[0]  = operand;
    assign sticky[0] = 1'b0;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            jam_shift_stage #(
                .W   (DATA_W),
                .AMT (1 << k)
            ) stage_i (
                .d_i      (chain[k]),
                .sticky_i (sticky[k]),
                .en_i     (count_ext[k]),
                .q_o      (chain[k+1]),
                .sticky_o (sticky[k+1])
            );
        end
    endgenerate

    always_comb begin
        unique case (range_sel)
            RANGE_ZERO:   result = operand;
            RANGE_INSIDE: result = {chain[STAGES][DATA_W-1:1], chain[STAGES][0] | sticky[STAGES]};
            RANGE_FLUSH:  result = {{(DATA_W-1){1'b0}}, |operand};
            default:      result = '0;
        endcase
    end

    assign out_hi_o = result[DATA_W-1:HALF_W];
    assign out_lo_o = result[HALF_W-1:0];

    always_comb begin
        assert_zero_passes_R1: assert ((count_i != '0) || (result == operand))
            else $error("zero count altered operand");
        assert_any_bit_kept_R6: assert ((|result) == (|operand))
            else $error("sticky OR lost or invented a bit");
        assert_never_grows_R6: assert (result <= operand)
            else $error("shift result larger than operand");
        assert_high_cleared_R4: assert ((int'(count_i) < int'(HALF_W)) || (out_hi_o == '0))
            else $error("high half not cleared at half-width count or more");
    end

endmodule

// File: tb/jam_shift_right_tb_top.sv
module jam_shift_right_tb_top;

    localparam int HALF_W = 64;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 2 * HALF_W;

    typedef struct {
        logic [DATA_W-1:0] expected;
        logic [DATA_W-1:0] stimulus;
        string             tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [HALF_W-1:0] in_hi;
    logic [HALF_W-1:0] in_lo;
    logic [CNT_W-1:0]  count;
    logic [HALF_W-1:0] out_hi;
    logic [HALF_W-1:0] out_lo;

    int       n_vec = 0;
    int       n_bad = 0;
    bit       done  = 1'b0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    jam_shift_right #(
        .HALF_W (HALF_W),
        .CNT_W  (CNT_W)
    ) dut_i (
        .in_hi_i  (in_hi),
        .in_lo_i  (in_lo),
        .count_i  (count),
        .out_hi_o (out_hi),
        .out_lo_o (out_lo)
    );

    function automatic logic [DATA_W-1:0] ref_shift(logic [DATA_W-1:0] v, int c);
        logic [2*DATA_W-1:0] wide;
        int                  ce;
        ce   = (c > DATA_W) ? DATA_W : c;
        wide = {v, {DATA_W{1'b0}}} >> ce;
        return {wide[2*DATA_W-1:DATA_W+1], wide[DATA_W] | (|wide[DATA_W-1:0])};
    endfunction

    function automatic string tag_of(int c);
        if (c == 0)      return "R1";
        if (c < HALF_W)  return "R2";
        if (c == HALF_W) return "R3";
        if (c < DATA_W)  return "R4";
        return "R5";
    endfunction

    task automatic drive(logic [DATA_W-1:0] v, int c);
        sb_item_t it;
        @(posedge clk);
        #1;
        in_hi = v[DATA_W-1:HALF_W];
        in_lo = v[HALF_W-1:0];
        count = CNT_W'(c);
        it.expected = ref_shift(v, c);
        it.stimulus = v;
        it.tag      = tag_of(c);
        sb_q.push_back(it);
    endtask

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s count=%0d actual=%h expected=%h", tag, count, act, exp);
        end
    endtask

    // Monitor: compares in the middle of the cycle, away from the drive point.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            sb_item_t it;
            logic [DATA_W-1:0] act;
            it  = sb_q.pop_front();
            act = {out_hi, out_lo};
            check(it.tag, act, it.expected);
            // R6: nonzero-ness preserved and result never grows
            check("R6", {{(DATA_W-1){1'b0}}, |act}, {{(DATA_W-1){1'b0}}, |it.stimulus});
            check("R6", {{(DATA_W-1){1'b0}}, act <= it.stimulus}, {{(DATA_W-1){1'b0}}, 1'b1});
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rv;
        in_hi = '0;
        in_lo = '0;
        count = '0;
        repeat (3) @(posedge clk);
        #2;
        // Reset state: zero operand, zero count gives zero result (R1)
        check("R1", {out_hi, out_lo}, '0);

        // R7: output follows input with no clock edge in between
        @(negedge clk);
        in_hi = 64'h8000_0000_0000_0001;
        in_lo = 64'h0000_0000_0000_0003;
        count = 8'd1;
        #1;
        check("R7", {out_hi, out_lo}, {64'h4000_0000_0000_0000, 64'h8000_0000_0000_0001});
        count = 8'd64;
        #1;
        check("R3", {out_hi, out_lo}, {64'h0, 64'h8000_0000_0000_0001});

        rst_n = 1'b1;

        // Directed boundary cases
        drive({64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321}, 0);   // R1 pass-through
        drive({64'h0, 64'h1}, 1);                                       // R2 only bit lost -> sticky
        drive({64'h0, 64'h2}, 1);                                       // R2 exact shift
        drive({64'hffff_0000_0000_0000, 64'h0}, 64);                    // R3 no sticky
        drive({64'hffff_0000_0000_0000, 64'h8000_0000_0000_0000}, 64);  // R3 sticky from low
        drive({64'h0000_0000_0000_0003, 64'h0}, 65);                    // R4 sticky from high
        drive({64'h8000_0000_0000_0000, 64'h0}, 127);                   // R4 top bit lands at 0
        drive({64'h0, 64'h1}, 128);                                     // R5 flush to one
        drive({64'h0, 64'h0}, 255);                                     // R5 flush of zero
        drive({64'h8000_0000_0000_0000, 64'h0}, 200);                   // R5

        // Sweep every count with several operand patterns
        for (int c = 0; c < 256; c++) begin
            drive({DATA_W{1'b1}}, c);
            drive({{(DATA_W-1){1'b0}}, 1'b1} << ((c > 0 && c <= DATA_W) ? c - 1 : 0), c);
            drive({{(DATA_W-1){1'b0}}, 1'b1} << ((c < DATA_W) ? c : DATA_W - 1), c);
            rv = {$urandom, $urandom, $urandom, $urandom};
            drive(rv, c);
            rv = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            drive(rv, c);
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule